// File: doc/BRIEF.md
# Three-Phase Imbalance Detector

This block watches a three-phase signal for loss of balance. On every accepted sample it adds the three signed phase values. On a healthy line the three phases cancel, so the sum is zero. The sum passes through a first-order exponential low-pass filter with a programmable time constant. An imbalance flag is raised while the magnitude of the filtered sum is greater than three times a programmable threshold. The threshold is given in the same units as one phase sample, for example half of the nominal amplitude.

The filter smooths out the moments when a healthy-looking sum appears only because an open phase happens to cross zero. It averages over at least one electrical period. Slow rotation therefore calls for a larger shift value, which gives a longer time constant. The detector only has meaning when the inputs carry three phases. In the two-phase orthogonal mode, and in the unused mode code, the filter is held at zero and the flag is held low.

Top module: `phase_balance_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the flag is low after that edge and the filter state is zero.
- R2: With `mode_i` = 2'b01 (three phases on three inputs) and `shift_i` = 0, an accepted sample whose |a+b+c| is greater than 3*`thresh_i` sets the flag. This holds for both signs of the sum.
- R3: The comparison is strict. A filtered magnitude equal to 3*`thresh_i` leaves the flag low. With `thresh_i` = 250 a sum of 750 does not trip the flag and a sum of 751 does.
- R4: Each accepted sample updates the filter state y as y := y + (x - y) / 2^k. Here x is the phase sum, k is `shift_i` (0 to 15), and the division is an arithmetic right shift on a value with 15 fractional bits. The flag compares the updated y.
- R5: When `mode_i` is 2'b00 (two-phase orthogonal) or 2'b11 (unused), the flag is low after the next clock edge and the filter state is cleared. After returning to a three-phase mode, filtering restarts from zero.
- R6: A cycle with `smp_valid_i` low leaves the filter state and the flag unchanged.
- R7: With `mode_i` = 2'b10 (three phases on two inputs), `ph_c_i` is ignored and the third phase is taken as -(a+b). The sum is therefore zero and the flag stays low.
- R8: The flag takes its new value on the clock edge that accepts the sample, and is visible from that edge on.
- R9: With k = 15 the flag responds slowly. A constant sum of 90000 with threshold 500 leaves the flag low after 500 samples and sets it by 600 samples.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample-valid strobe; phase inputs are taken in this cycle |
| ph_a_i | input | SAMPLE_W | Phase A sample, signed |
| ph_b_i | input | SAMPLE_W | Phase B sample, signed |
| ph_c_i | input | SAMPLE_W | Phase C sample, signed (ignored in mode 2'b10) |
| mode_i | input | 2 | Input format: 00 two-phase, 01 three-phase three inputs, 10 three-phase two inputs, 11 unused |
| thresh_i | input | THR_W | Per-phase threshold, unsigned, same units as a sample |
| shift_i | input | SHIFT_W | Filter shift k; the time constant is about 2^k samples |
| imbalance_o | output | 1 | Imbalance flag |

## Verification
On every cycle the assertions check the following:
- the flag is cleared by reset and by a non-three-phase mode;
- the flag holds steady through cycles without a valid sample;
- with an unfiltered (k = 0) sample, the flag follows the strict comparison of |a+b+c| against 3*threshold;
- the flag stays low when the third phase is reconstructed from the other two.

Only the bench scenarios can show the following:
- the filter trajectory over several samples at k = 2, rising and decaying;
- the restart from zero after leaving and re-entering a three-phase mode;
- the slow approach at k = 15;
- the exact edge on which the flag changes.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [1:0] {
        MODE_ORTHO = 2'b00,
        MODE_3IN   = 2'b01,
        MODE_2IN   = 2'b10,
        MODE_UNUSED = 2'b11
    } pbm_mode_e;

    typedef struct packed {
        logic take;    // sample accepted this cycle
        logic active;  // a three-phase mode is selected
    } pbm_ctrl_t;

    function automatic logic pbm_is_three_phase(input logic [1:0] m);
        return (m == MODE_3IN) || (m == MODE_2IN);
    endfunction

    function automatic int pbm_max(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/pbm_phase_sum.sv
module pbm_phase_sum
    import pbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SUM_W    = SAMPLE_W + 2
) (
    input  logic signed [SAMPLE_W-1:0] ph_a,
    input  logic signed [SAMPLE_W-1:0] ph_b,
    input  logic signed [SAMPLE_W-1:0] ph_c,
    input  logic        [1:0]          mode,
    output logic signed [SUM_W-1:0]    sum,
    output logic                       active
);
    logic signed [SUM_W-1:0] a_ext, b_ext, c_ext, c_eff, ab;

    always_comb begin
        a_ext = SUM_W'(ph_a);
        b_ext = SUM_W'(ph_b);
        c_ext = SUM_W'(ph_c);
        ab    = a_ext + b_ext;
        // Two-input three-phase: third phase rebuilt from the other two
        c_eff = (mode == MODE_2IN) ? -ab : c_ext;
        sum    = ab + c_eff;
        active = pbm_is_three_phase(mode);
    end
endmodule

// File: rtl/pbm_ema_filter.sv
module pbm_ema_filter #(
    parameter int SUM_W   = 18,
    parameter int SHIFT_W = 4,
    parameter int FRAC_W  = 15,
    parameter int ACC_W   = SUM_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     take,
    input  logic signed [SUM_W-1:0]  x,
    input  logic        [SHIFT_W-1:0] k,
    output logic signed [ACC_W-1:0]  y_next
);
    localparam int DIFF_W = ACC_W + 1;

    logic signed [ACC_W-1:0]  y_q;
    logic signed [ACC_W-1:0]  x_fix;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] step;
    logic signed [DIFF_W-1:0] sum_w;

    always_comb begin
        x_fix  = {x, {FRAC_W{1'b0}}};
        diff   = DIFF_W'(x_fix) - DIFF_W'(y_q);
        step   = diff >>> k;
        sum_w  = DIFF_W'(y_q) + step;
        // y_next lies between y_q and x_fix, so it fits in ACC_W bits
        y_next = sum_w[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            y_q <= '0;
        end else if (take) begin
            y_q <= y_next;
        end
    end
endmodule

// File: rtl/pbm_threshold_cmp.sv
module pbm_threshold_cmp #(
    parameter int ACC_W  = 33,
    parameter int THR_W  = 16,
    parameter int FRAC_W = 15,
    parameter int CMP_W  = 35
) (
    input  logic signed [ACC_W-1:0] y,
    input  logic        [THR_W-1:0] thresh,
    output logic                    over
);
    logic signed [CMP_W-1:0] y_ext;
    logic        [CMP_W-1:0] mag;
    logic        [CMP_W-1:0] limit;
    logic        [THR_W+1:0] thr3;

    always_comb begin
        y_ext = CMP_W'(y);
        mag   = (y_ext < 0) ? CMP_W'(-y_ext) : CMP_W'(y_ext);
        thr3  = (THR_W+2)'(thresh) * (THR_W+2)'(3);
        limit = CMP_W'(thr3) << FRAC_W;
        over  = mag > limit;
    end
endmodule

// File: rtl/phase_balance_monitor.sv
module phase_balance_monitor
    import pbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 16,
    parameter int SHIFT_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid_i,
    input  logic signed [SAMPLE_W-1:0] ph_a_i,
    input  logic signed [SAMPLE_W-1:0] ph_b_i,
    input  logic signed [SAMPLE_W-1:0] ph_c_i,
    input  logic        [1:0]          mode_i,
    input  logic        [THR_W-1:0]    thresh_i,
    input  logic        [SHIFT_W-1:0]  shift_i,
    output logic                       imbalance_o
);
    localparam int SUM_W  = SAMPLE_W + 2;
    localparam int FRAC_W = (2 ** SHIFT_W) - 1;
    localparam int ACC_W  = SUM_W + FRAC_W;
    localparam int CMP_W  = pbm_max(ACC_W, THR_W + 2 + FRAC_W) + 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] y_next;
    logic                    over;
    logic                    active;
    pbm_ctrl_t               ctrl;
    logic                    flag_q;

    pbm_phase_sum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_sum (
        .ph_a(ph_a_i), .ph_b(ph_b_i), .ph_c(ph_c_i),
        .mode(mode_i), .sum(sum), .active(active)
    );

    always_comb begin
        ctrl.active = active;
        ctrl.take   = smp_valid_i & active;
    end

    pbm_ema_filter #(
        .SUM_W(SUM_W), .SHIFT_W(SHIFT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
    ) u_filt (
        .clk(clk), .rst(rst), .clear(!ctrl.active), .take(ctrl.take),
        .x(sum), .k(shift_i), .y_next(y_next)
    );

    pbm_threshold_cmp #(
        .ACC_W(ACC_W), .THR_W(THR_W), .FRAC_W(FRAC_W), .CMP_W(CMP_W)
    ) u_cmp (
        .y(y_next), .thresh(thresh_i), .over(over)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctrl.active) begin
            flag_q <= 1'b0;
        end else if (ctrl.take) begin
            flag_q <= over;
        end
    end

    assign imbalance_o = flag_q;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 16,
    parameter int SHIFT_W  = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       smp_valid_i,
    input logic signed [SAMPLE_W-1:0] ph_a_i,
    input logic signed [SAMPLE_W-1:0] ph_b_i,
    input logic signed [SAMPLE_W-1:0] ph_c_i,
    input logic        [1:0]          mode_i,
    input logic        [THR_W-1:0]    thresh_i,
    input logic        [SHIFT_W-1:0]  shift_i,
    input logic                       imbalance_o
);
    localparam int SW = SAMPLE_W + 3;

    logic signed [SW-1:0] chk_sum;
    logic        [SW-1:0] chk_mag;
    logic        [SW-1:0] chk_lim;
    logic                 three_ph;

    always_comb begin
        chk_sum  = SW'(ph_a_i) + SW'(ph_b_i) + SW'(ph_c_i);
        chk_mag  = (chk_sum < 0) ? SW'(-chk_sum) : SW'(chk_sum);
        chk_lim  = SW'(thresh_i) * SW'(3);
        three_ph = (mode_i == 2'b01) || (mode_i == 2'b10);
    end

    AST_RESET_CLEARS_FLAG: assert property (@(posedge clk) rst |=> !imbalance_o); // R1

    AST_TRIP_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (smp_valid_i && mode_i == 2'b01 && shift_i == '0 && chk_mag > chk_lim)
        |=> imbalance_o); // R2

    AST_NO_TRIP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (smp_valid_i && mode_i == 2'b01 && shift_i == '0 && chk_mag <= chk_lim)
        |=> !imbalance_o); // R3

    AST_OFF_OUTSIDE_3PH: assert property (@(posedge clk) disable iff (rst)
        !three_ph |=> !imbalance_o); // R5

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid_i && three_ph) |=> $stable(imbalance_o)); // R6

    AST_TWO_WIRE_LOW: assert property (@(posedge clk) disable iff (rst)
        (smp_valid_i && mode_i == 2'b10 && shift_i == '0) |=> !imbalance_o); // R7
endmodule

bind phase_balance_monitor pbm_checker #(
    .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .SHIFT_W(SHIFT_W)
) u_pbm_checker (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i),
    .ph_a_i(ph_a_i), .ph_b_i(ph_b_i), .ph_c_i(ph_c_i),
    .mode_i(mode_i), .thresh_i(thresh_i), .shift_i(shift_i),
    .imbalance_o(imbalance_o)
);

// File: tb/phase_balance_monitor_tb_top.sv
module phase_balance_monitor_tb_top;
    localparam int SAMPLE_W = 16;
    localparam int THR_W    = 16;
    localparam int SHIFT_W  = 4;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       smp_valid_i = 1'b0;
    logic signed [SAMPLE_W-1:0] ph_a_i = '0;
    logic signed [SAMPLE_W-1:0] ph_b_i = '0;
    logic signed [SAMPLE_W-1:0] ph_c_i = '0;
    logic        [1:0]          mode_i = 2'b01;
    logic        [THR_W-1:0]    thresh_i = 16'd500;
    logic        [SHIFT_W-1:0]  shift_i = '0;
    logic                       imbalance_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    phase_balance_monitor #(
        .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .SHIFT_W(SHIFT_W)
    ) dut_i (
        .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i),
        .ph_a_i(ph_a_i), .ph_b_i(ph_b_i), .ph_c_i(ph_c_i),
        .mode_i(mode_i), .thresh_i(thresh_i), .shift_i(shift_i),
        .imbalance_o(imbalance_o)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Present one sample for one cycle; return at the following negedge
    task automatic send(input int a, input int b, input int c);
        ph_a_i = SAMPLE_W'(a); ph_b_i = SAMPLE_W'(b); ph_c_i = SAMPLE_W'(c);
        smp_valid_i = 1'b1;
        @(negedge clk);
        smp_valid_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(imbalance_o, 1'b0, "R1 flag after reset");
    endtask

    task automatic t_threshold();
        do_reset();
        mode_i = 2'b01; shift_i = 0; thresh_i = 16'd500;
        send(1000, 500, 0);    chk(imbalance_o, 1'b0, "R3 sum 1500 equals limit");
        send(1000, 501, 0);    chk(imbalance_o, 1'b1, "R2 sum 1501 trips");
        send(-1000, -501, 0);  chk(imbalance_o, 1'b1, "R2 sum -1501 trips");
        send(1000, -500, -500); chk(imbalance_o, 1'b0, "R3 balanced clears");
        thresh_i = 16'd250;
        send(750, 0, 0);       chk(imbalance_o, 1'b0, "R3 thr 250 sum 750");
        send(751, 0, 0);       chk(imbalance_o, 1'b1, "R3 thr 250 sum 751");
    endtask

    task automatic t_edge_timing();
        do_reset();
        mode_i = 2'b01; shift_i = 0; thresh_i = 16'd500;
        ph_a_i = 16'sd2000; ph_b_i = 0; ph_c_i = 0; smp_valid_i = 1'b1;
        #9;
        chk(imbalance_o, 1'b0, "R8 flag before accepting edge");
        @(negedge clk);
        smp_valid_i = 1'b0;
        chk(imbalance_o, 1'b1, "R8 flag after accepting edge");
    endtask

    task automatic t_hold();
        // state: flag high from previous scenario
        ph_a_i = 0; ph_b_i = 0; ph_c_i = 0; smp_valid_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(imbalance_o, 1'b1, "R6 high flag held without valid");
        send(0, 0, 0);
        ph_a_i = 16'sd5000;
        repeat (5) @(negedge clk);
        chk(imbalance_o, 1'b0, "R6 low flag held without valid");
    endtask

    task automatic t_filter();
        real y;
        real x;
        do_reset();
        mode_i = 2'b01; shift_i = 4'd2; thresh_i = 16'd500;
        y = 0.0;
        for (int i = 0; i < 5; i++) begin
            x = (i < 3) ? 4000.0 : 0.0;
            if (i < 3) send(2000, 2000, 0); else send(0, 0, 0);
            y = y + (x - y) / 4.0;
            chk(imbalance_o, ((y > 1500.0) || (y < -1500.0)) ? 1'b1 : 1'b0,
                $sformatf("R4 k=2 step %0d", i));
        end
    endtask

    task automatic t_mode_off();
        do_reset();
        mode_i = 2'b01; shift_i = 0; thresh_i = 16'd500;
        send(1000, 1000, 1000);
        chk(imbalance_o, 1'b1, "R5 precondition flag high");
        mode_i = 2'b00;
        @(negedge clk);
        chk(imbalance_o, 1'b0, "R5 two-phase mode clears flag");
        send(9000, 9000, 9000);
        chk(imbalance_o, 1'b0, "R5 two-phase mode ignores sample");
        mode_i = 2'b11;
        send(9000, 9000, 9000);
        chk(imbalance_o, 1'b0, "R5 unused mode keeps flag low");
        mode_i = 2'b01; shift_i = 4'd2;
        send(2000, 2000, 0);   // from zero: y = 1000
        chk(imbalance_o, 1'b0, "R5 filter restarts from zero");
    endtask

    task automatic t_two_wire();
        do_reset();
        mode_i = 2'b01; shift_i = 0; thresh_i = 16'd500;
        send(3000, 0, 0);
        chk(imbalance_o, 1'b1, "R7 precondition flag high");
        mode_i = 2'b10;
        send(3000, 0, 5000);
        chk(imbalance_o, 1'b0, "R7 phase c ignored");
        send(3000, 3000, -32768);
        chk(imbalance_o, 1'b0, "R7 rebuilt phase cancels");
        mode_i = 2'b01;
    endtask

    task automatic t_slow();
        do_reset();
        mode_i = 2'b01; shift_i = 4'd15; thresh_i = 16'd500;
        for (int i = 0; i < 500; i++) send(30000, 30000, 30000);
        chk(imbalance_o, 1'b0, "R9 k=15 after 500 samples");
        for (int i = 0; i < 100; i++) send(30000, 30000, 30000);
        chk(imbalance_o, 1'b1, "R9 k=15 after 600 samples");
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_threshold();
                t_edge_timing();
                t_hold();
                t_filter();
                t_mode_off();
                t_two_wire();
                t_slow();
                done = 1'b1;
            end
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog actual=timeout expected=completion");
                end
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule